// File: doc/BRIEF.md
# Shift-Rotate Operand Unit

A purely combinational 32-bit shifter placed in front of the second operand of an ALU. It takes the operand and applies one of four operations: logical shift left, logical shift right, arithmetic shift right or rotate right. The shift amount runs from 0 to 31. It also returns the carry-out that the ALU needs when it updates its flags. Arithmetic shift left needs no separate code, because it behaves the same as logical shift left. A separate select chooses rotate-with-extend instead. That mode moves the operand right by one place and treats the incoming carry flag as a 33rd bit.

The ALU, the choice between a register and an immediate as the source of the shift amount, and any rotated-immediate constant scheme all sit outside this block. The result and the carry-out follow the inputs within the same cycle. The block holds no state, so it has no state machine, clock or reset.

Top module: `shop_unit`

## Requirements
- R1: With `ext_i` low, `amt_i` nonzero and `kind_i` = 2'b00 (shift left), `res_o` is `opnd_i` moved left by `amt_i` places, and the vacated low bits are zero.
- R2: With `ext_i` low, `amt_i` nonzero and `kind_i` = 2'b01 (logical right), `res_o` is `opnd_i` moved right by `amt_i` places, and the vacated high bits are zero.
- R3: With `ext_i` low, `amt_i` nonzero and `kind_i` = 2'b10 (arithmetic right), `res_o` is `opnd_i` moved right by `amt_i` places, and every vacated high bit is a copy of `opnd_i[31]`.
- R4: With `ext_i` low, `amt_i` nonzero and `kind_i` = 2'b11 (rotate right), `res_o` is `opnd_i` rotated right by `amt_i` places, so that bit 0 wraps into bit 31.
- R5: With `ext_i` low and `amt_i` = 0, `res_o` equals `opnd_i` and `cout_o` equals `cin_i`, whatever the value of `kind_i`.
- R6: With `ext_i` low and `amt_i` nonzero, `cout_o` is the last bit moved out of the operand. For shift left that bit is `opnd_i[32-amt_i]`. For the three right-moving kinds it is `opnd_i[amt_i-1]`.
- R7: With `ext_i` high, `res_o` = {`cin_i`, `opnd_i[31:1]`} and `cout_o` = `opnd_i[0]`. Both `kind_i` and `amt_i` are ignored in this mode.
- R8: The outputs depend only on the present inputs. Applying the same input vector again, after other vectors in between, gives the same result and carry.

Encoding of `kind_i`: 2'b00 shift left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to shift |
| kind_i | input | 2 | Shift kind (encoding given under R1 to R4) |
| amt_i | input | 5 | Shift amount, 0 to 31 |
| ext_i | input | 1 | Selects the one-bit rotate through carry |
| cin_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted operand |
| cout_o | output | 1 | Shifter carry-out |

## Verification
Both `res_o` and `cout_o` are due zero cycles after a stimulus, because no register lies between any input and either output. The bench applies each vector just after a rising edge and samples the outputs at the next falling edge, half a period later. By then the combinational paths have settled, and no input changes during the sampling window. The same-cycle relations are also checked by the bound checker whenever an input changes.

// File: rtl/shop_pkg.sv
package shop_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_SIGN = 2'b01,
        FILL_WRAP = 2'b10
    } fill_e;

endpackage

// File: rtl/shop_bitrev.sv
module shop_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign dout_o[i] = din_i[W-1-i];
    end

endmodule

// File: rtl/shop_right_stages.sv
module shop_right_stages
    import shop_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    input  fill_e         fill_i,
    input  logic          sign_i,
    output logic [W-1:0]  data_o
);

    logic [W-1:0] stg [AW+1];

    assign stg[0] = data_i;

    // Log-depth stages: stage s moves right by 2**s when amt_i[s] is set.
    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [K-1:0] top;
        logic [W-1:0] moved;

        always_comb begin
            unique case (fill_i)
                FILL_WRAP: top = stg[s][K-1:0];
                FILL_SIGN: top = {K{sign_i}};
                default:   top = '0;
            endcase
        end

        assign moved      = {top, stg[s][W-1:K]};
        assign stg[s+1]   = amt_i[s] ? moved : stg[s];
    end

    assign data_o = stg[AW];

endmodule

// File: rtl/shop_carry_pick.sv
module shop_carry_pick #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    input  logic          cin_i,
    output logic          cout_o
);

    logic [AW-1:0] idx;

    // Last bit out of a right move by amt is bit amt-1 of its input.
    assign idx    = amt_i - AW'(1);
    assign cout_o = (amt_i == '0) ? cin_i : data_i[idx];

endmodule

// File: rtl/shop_unit.sv
module shop_unit
    import shop_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] amt_i,
    input  logic          ext_i,
    input  logic          cin_i,
    output logic [W-1:0]  res_o,
    output logic          cout_o
);

    shift_kind_e kind;
    fill_e       fill;
    logic        is_left;
    logic [W-1:0] opnd_rev, pre, raw, raw_rev, shifted;
    logic         move_cout;

    assign kind    = shift_kind_e'(kind_i);
    assign is_left = (kind == SH_LSL);

    // A left shift is a right shift of the bit-reversed operand.
    shop_bitrev #(.W(W)) u_rev_in (
        .din_i  (opnd_i),
        .dout_o (opnd_rev)
    );

    assign pre = is_left ? opnd_rev : opnd_i;

    always_comb begin
        unique case (kind)
            SH_ASR:  fill = FILL_SIGN;
            SH_ROR:  fill = FILL_WRAP;
            default: fill = FILL_ZERO;
        endcase
    end

    shop_right_stages #(.W(W), .AW(AW)) u_stages (
        .data_i (pre),
        .amt_i  (amt_i),
        .fill_i (fill),
        .sign_i (opnd_i[W-1]),
        .data_o (raw)
    );

    shop_bitrev #(.W(W)) u_rev_out (
        .din_i  (raw),
        .dout_o (raw_rev)
    );

    assign shifted = is_left ? raw_rev : raw;

    shop_carry_pick #(.W(W), .AW(AW)) u_carry (
        .data_i (pre),
        .amt_i  (amt_i),
        .cin_i  (cin_i),
        .cout_o (move_cout)
    );

    // One-bit rotate through carry overrides kind and amount.
    assign res_o  = ext_i ? {cin_i, opnd_i[W-1:1]} : shifted;
    assign cout_o = ext_i ? opnd_i[0] : move_cout;

endmodule

// File: rtl/shop_unit_chk.sv
module shop_unit_chk #(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input logic [W-1:0]  opnd_i,
    input logic [1:0]    kind_i,
    input logic [AW-1:0] amt_i,
    input logic          ext_i,
    input logic          cin_i,
    input logic [W-1:0]  res_o,
    input logic          cout_o
);

    int n;

    always_comb begin
        n = int'(amt_i);
        if (!$isunknown({opnd_i, kind_i, amt_i, ext_i, cin_i, res_o, cout_o})) begin
            if (ext_i) begin
                a_r7_extend: assert (res_o == {cin_i, opnd_i[W-1:1]} && cout_o == opnd_i[0])
                    else $error("R7 extend mismatch");
            end else if (n == 0) begin
                a_r5_pass: assert (res_o == opnd_i && cout_o == cin_i)
                    else $error("R5 pass-through mismatch");
            end else begin
                unique case (kind_i)
                    2'b00: begin
                        a_r1_lsl: assert (res_o == (opnd_i << n))
                            else $error("R1 left mismatch");
                        a_r6_carry_left: assert (cout_o == opnd_i[W-n])
                            else $error("R6 left carry mismatch");
                    end
                    2'b01: begin
                        a_r2_lsr: assert (res_o == (opnd_i >> n))
                            else $error("R2 logical right mismatch");
                        a_r6_carry_right: assert (cout_o == opnd_i[n-1])
                            else $error("R6 right carry mismatch");
                    end
                    2'b10: begin
                        a_r3_asr: assert (res_o == W'($signed(opnd_i) >>> n))
                            else $error("R3 arithmetic right mismatch");
                        a_r6_carry_asr: assert (cout_o == opnd_i[n-1])
                            else $error("R6 arithmetic carry mismatch");
                    end
                    default: begin
                        a_r4_ror: assert (res_o == ((opnd_i >> n) | (opnd_i << (W-n))))
                            else $error("R4 rotate mismatch");
                        a_r6_carry_ror: assert (cout_o == opnd_i[n-1])
                            else $error("R6 rotate carry mismatch");
                    end
                endcase
            end
        end
    end

endmodule

bind shop_unit shop_unit_chk #(.W(W)) u_chk (
    .opnd_i (opnd_i),
    .kind_i (kind_i),
    .amt_i  (amt_i),
    .ext_i  (ext_i),
    .cin_i  (cin_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/sim_shop_unit.sv
module sim_shop_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd;
    logic [1:0]   kind;
    logic [4:0]   amt;
    logic         ext;
    logic         cin;
    logic [W-1:0] res;
    logic         cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shop_unit u0 (
        .opnd_i (opnd),
        .kind_i (kind),
        .amt_i  (amt),
        .ext_i  (ext),
        .cin_i  (cin),
        .res_o  (res),
        .cout_o (cout)
    );

    // Reference model: result and carry packed as {carry, result}.
    function automatic logic [W:0] model(logic [W-1:0] op, logic [1:0] k,
                                         int a, logic e, logic c);
        logic [W:0]   t;
        logic [2*W-1:0] d;
        if (e) return {op[0], c, op[W-1:1]};
        if (a == 0) return {c, op};
        case (k)
            2'b00: begin t = {1'b0, op} << a; return {t[W], t[W-1:0]}; end
            2'b01: begin t = {op, 1'b0} >> a; return {t[0], t[W:1]}; end
            2'b10: begin t = W'(1) ? ({op, 1'b0}) : '0;
                         t = (W+1)'($signed(t) >>> a); return {t[0], t[W:1]}; end
            default: begin d = {op, op} >> a; return {op[a-1], d[W-1:0]}; end
        endcase
    endfunction

    task automatic apply(logic [W-1:0] op, logic [1:0] k, int a, logic e,
                         logic c, string tag);
        logic [W:0] exp;
        @(posedge clk);
        opnd = op; kind = k; amt = a[4:0]; ext = e; cin = c;
        @(negedge clk);
        exp = model(op, k, a, e, c);
        checks++;
        if ({cout, res} !== exp) begin
            fails++;
            $display("FAIL %s: op=%h kind=%0d amt=%0d ext=%0b cin=%0b got c=%0b r=%h exp c=%0b r=%h",
                     tag, op, k, a, e, c, cout, res, exp[W], exp[W-1:0]);
        end
    endtask

    function automatic string kind_tag(logic [1:0] k, int a);
        if (a == 0) return "R5";
        case (k)
            2'b00:   return "R1/R6";
            2'b01:   return "R2/R6";
            2'b10:   return "R3/R6";
            default: return "R4/R6";
        endcase
    endfunction

    initial begin
        logic [W-1:0] first_res;
        logic         first_cout;
        void'($urandom(32'h5a17));
        opnd = '0; kind = '0; amt = '0; ext = 1'b0; cin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res !== '0 || cout !== 1'b0) begin
            fails++;
            $display("FAIL R5 reset state: got r=%h c=%0b exp r=0 c=0", res, cout);
        end
        rst_n = 1'b1;

        // Directed corners.
        apply(32'h8000_0000, 2'b10, 31, 1'b0, 1'b0, "R3");
        apply(32'h8000_0000, 2'b01, 31, 1'b0, 1'b0, "R2");
        apply(32'h0000_0001, 2'b00, 31, 1'b0, 1'b0, "R1");
        apply(32'h0000_0001, 2'b11,  1, 1'b0, 1'b0, "R4");
        apply(32'h0000_0002, 2'b00, 31, 1'b0, 1'b1, "R6");
        apply(32'hDEAD_BEEF, 2'b11,  0, 1'b0, 1'b1, "R5");
        apply(32'h0000_0001, 2'b01, 17, 1'b1, 1'b1, "R7");
        apply(32'h0000_0000, 2'b10,  5, 1'b1, 1'b0, "R7");

        // Every kind and amount with random operands and carry.
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 32; a++) begin
                for (int r = 0; r < 6; r++) begin
                    apply($urandom, k[1:0], a, 1'b0, 1'(($urandom)), kind_tag(k[1:0], a));
                end
            end
        end

        // Rotate through carry with random kind and amount present (R7).
        for (int r = 0; r < 150; r++) begin
            apply($urandom, 2'($urandom), int'($urandom % 32), 1'b1, 1'($urandom), "R7");
        end

        // R8: repeat a vector after unrelated ones.
        apply(32'h1234_5678, 2'b10, 9, 1'b0, 1'b1, "R8");
        first_res = res; first_cout = cout;
        apply(32'hFFFF_0000, 2'b00, 3, 1'b0, 1'b0, "R8");
        apply(32'h0F0F_0F0F, 2'b11, 0, 1'b1, 1'b1, "R8");
        apply(32'h1234_5678, 2'b10, 9, 1'b0, 1'b1, "R8");
        checks++;
        if (res !== first_res || cout !== first_cout) begin
            fails++;
            $display("FAIL R8 repeat: got r=%h c=%0b exp r=%h c=%0b", res, cout, first_res, first_cout);
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule